// File: doc/BRIEF.md
# Full-Duplex Serial Peripheral Master Engine

This block is a serial peripheral (SPI, Motorola format) master. It moves data words from a 32-entry transmit queue onto the serial line and, in the same frames, gathers the bits shifted in from the slave into a 32-entry receive queue. Software programs it through a small word-wide register port. The port sets the frame length (4, 8 or 16 bits), the clock idle level and capture edge, the serial clock divider, a global run bit, and a one-hot chip-select register for two slaves. The port also returns both queue fill levels, a status word and the data words received.

The chip selects follow the select register directly. Frames run back to back for as long as the engine is running, a slave is selected and transmit data is waiting. The configuration registers only accept writes while the engine is stopped. Clearing the run bit during a frame abandons that frame.

Top module: `spi_master_engine`

## Requirements
- R1: After reset, the status word reads 0x000C and both fill levels read 0. The control register reads 0x0001 (8-bit frames, mode 0) and the divider register reads 2. Both chip selects are high, busy is low and SCLK is low.
- R2: The register addresses are: 0 control, 1 divider, 2 run, 3 select, 4 TX level, 5 RX level, 6 status, 7 TX data (write pushes a word), 8 RX data (a read with rdEn pops a word). In the control register, bit 7 is clock polarity, bit 6 is clock phase and bits [1:0] are the frame size. All other control bits read back as 0.
- R3: While no frame is running, SCLK rests at the polarity level. MOSI carries the frame MSB first. With phase 0, each bit is presented before the leading SCLK edge and both sides sample on that edge. With phase 1, each bit is presented on the leading edge and sampled on the trailing edge. The received word is the sampled MISO bits, MSB first.
- R4: Frame size code 0 selects 4-bit frames, code 2 selects 16-bit frames, and codes 1 and 3 select 8-bit frames. Only the low N bits of a TX word are sent. A received word carries the data in its low N bits and zeros above.
- R5: Bit 0 of the divider value is ignored, and values below 2 act as 2. Each SCLK half period lasts divider/2 source clock cycles. Busy stays high for 2·N·(divider/2)+1 cycles per frame.
- R6: Chip select i is low exactly when bit i of the select register is 1. Writing 0 raises both.
- R7: A frame starts one cycle after all of these hold: the run bit is 1, the TX queue is non-empty and at least one select bit is set.
- R8: Both queues are first-in first-out and hold 32 words. A push to a full TX queue is ignored. A pop of an empty RX queue has no effect. A frame that completes while the RX queue is full is dropped.
- R9: Status bits are: bit 0 busy, bit 1 TX queue full, bit 2 TX queue empty, bit 3 RX queue empty, bit 4 RX queue full.
- R10: Clearing the run bit during a frame drops busy on the next cycle and returns SCLK to the polarity level. No word is written into the RX queue for that frame.
- R11: Writes to the control and divider registers are ignored while the run bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (pops the RX queue at address 8) |
| addr | input | 4 | Register address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, combinational from addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slaves |
| miso | input | 1 | Serial data from the selected slave |
| csN | output | 2 | Active-low chip selects |
| busy | output | 1 | High while a frame is in progress |

## Verification
A register write takes effect at the clock edge on which it is presented. Read data is combinational in the same cycle. A TX data write therefore raises busy one edge later, and busy then stays high for exactly 2·N·(divider/2)+1 cycles. The RX level increments on the edge where busy falls. An abort drops busy one edge after the run bit is cleared. The bench changes inputs on falling clock edges and samples every output on falling edges as well. It counts busy cycles in whole-cycle steps, so each expected value is fixed arithmetic from the programmed divider and frame size. A bench slave model follows SCLK, drives and captures bits for all four modes and all three frame sizes, and checks both directions of every frame.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam logic [3:0] REG_CTRL   = 4'd0;
  localparam logic [3:0] REG_BAUD   = 4'd1;
  localparam logic [3:0] REG_RUN    = 4'd2;
  localparam logic [3:0] REG_SELECT = 4'd3;
  localparam logic [3:0] REG_TXLVL  = 4'd4;
  localparam logic [3:0] REG_RXLVL  = 4'd5;
  localparam logic [3:0] REG_STATUS = 4'd6;
  localparam logic [3:0] REG_TXDATA = 4'd7;
  localparam logic [3:0] REG_RXDATA = 4'd8;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} engState_t;

  // strobes from control to datapath, each valid for one cycle
  typedef struct packed {
    logic loadFrame;
    logic leadEdge;
    logic trailEdge;
    logic pushRx;
  } engStrobe_t;

  function automatic logic [4:0] frameBits(input logic [1:0] sizeCode);
    case (sizeCode)
      2'd0:    return 5'd4;
      2'd2:    return 5'd16;
      default: return 5'd8;
    endcase
  endfunction

  // index of the final SCLK edge of a frame: 2*N-1
  function automatic logic [4:0] lastEdgeIdx(input logic [1:0] sizeCode);
    case (sizeCode)
      2'd0:    return 5'd7;
      2'd2:    return 5'd31;
      default: return 5'd15;
    endcase
  endfunction

endpackage

// File: rtl/spi_eng_fifo.sv
module spi_eng_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [LVL_W-1:0] count;
  logic doPush, doPop;

  assign full   = (count == LVL_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdata  = mem[rdPtr];
  assign level  = count;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + LVL_W'(1);
        2'b01:   count <= count - LVL_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spi_eng_datapath.sv
module spi_eng_datapath
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int BAUD_W = 16,
  parameter int SEL_W  = 2,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [3:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  engStrobe_t        strobe,
  input  logic              busy,
  input  logic              miso,
  output logic              mosi,
  output logic [SEL_W-1:0]  csN,
  output logic              cfgCpol,
  output logic [1:0]        cfgSize,
  output logic [BAUD_W-1:0] cfgBaud,
  output logic              runEn,
  output logic              txEmpty,
  output logic              selAny,
  output logic [LVL_W-1:0]  txLevel,
  output logic [LVL_W-1:0]  rxLevel
);
  logic             cpolReg, cphaReg;
  logic [1:0]       sizeReg;
  logic [BAUD_W-1:0] baudReg;
  logic             runReg;
  logic [SEL_W-1:0] selReg;

  logic txFull, rxFull, rxEmpty;
  logic txPush, rxPop;
  logic [DATA_W-1:0] txHead, rxHead, txAligned, rxWord, frameMask;
  logic [DATA_W-1:0] txShift, rxShift;
  logic [4:0] nBits, alignAmt;
  logic mosiReg, sampleNow, shiftNow;

  // register writes; configuration only while stopped
  always_ff @(posedge clk) begin
    if (rst) begin
      cpolReg <= 1'b0;
      cphaReg <= 1'b0;
      sizeReg <= 2'd1;
      baudReg <= BAUD_W'(2);
      runReg  <= 1'b0;
      selReg  <= '0;
    end else if (wrEn) begin
      case (addr)
        REG_CTRL: if (!runReg) begin
          cpolReg <= wrData[7];
          cphaReg <= wrData[6];
          sizeReg <= wrData[1:0];
        end
        REG_BAUD:   if (!runReg) baudReg <= wrData[BAUD_W-1:0];
        REG_RUN:    runReg <= wrData[0];
        REG_SELECT: selReg <= wrData[SEL_W-1:0];
        default: ;
      endcase
    end
  end

  assign txPush = wrEn && (addr == REG_TXDATA);
  assign rxPop  = rdEn && (addr == REG_RXDATA);

  spi_eng_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(txPush), .pop(strobe.loadFrame),
    .wdata(wrData), .rdata(txHead), .level(txLevel),
    .full(txFull), .empty(txEmpty)
  );

  spi_eng_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(strobe.pushRx), .pop(rxPop),
    .wdata(rxWord), .rdata(rxHead), .level(rxLevel),
    .full(rxFull), .empty(rxEmpty)
  );

  // frame alignment: MSB of the frame sits at the top of the shifter
  assign nBits     = frameBits(sizeReg);
  assign alignAmt  = 5'(DATA_W) - nBits;
  assign txAligned = txHead << alignAmt;
  assign frameMask = (DATA_W'(1) << nBits) - DATA_W'(1);
  assign rxWord    = rxShift & frameMask;

  assign sampleNow = cphaReg ? strobe.trailEdge : strobe.leadEdge;
  assign shiftNow  = cphaReg ? strobe.leadEdge  : strobe.trailEdge;

  always_ff @(posedge clk) begin
    if (rst) begin
      txShift <= '0;
      rxShift <= '0;
      mosiReg <= 1'b0;
    end else if (strobe.loadFrame) begin
      txShift <= txAligned;
      rxShift <= '0;
      mosiReg <= cphaReg ? 1'b0 : txAligned[DATA_W-1];
    end else begin
      if (shiftNow) begin
        txShift <= txShift << 1;
        mosiReg <= cphaReg ? txShift[DATA_W-1] : txShift[DATA_W-2];
      end
      if (sampleNow) rxShift <= {rxShift[DATA_W-2:0], miso};
    end
  end

  assign mosi    = mosiReg;
  assign csN     = ~selReg;
  assign selAny  = |selReg;
  assign cfgCpol = cpolReg;
  assign cfgSize = sizeReg;
  assign cfgBaud = baudReg;
  assign runEn   = runReg;

  always_comb begin
    rdData = '0;
    case (addr)
      REG_CTRL:   rdData = DATA_W'({cpolReg, cphaReg, 4'b0000, sizeReg});
      REG_BAUD:   rdData = DATA_W'(baudReg);
      REG_RUN:    rdData = DATA_W'(runReg);
      REG_SELECT: rdData = DATA_W'(selReg);
      REG_TXLVL:  rdData = DATA_W'(txLevel);
      REG_RXLVL:  rdData = DATA_W'(rxLevel);
      REG_STATUS: rdData = DATA_W'({rxFull, rxEmpty, txEmpty, txFull, busy});
      REG_RXDATA: rdData = rxHead;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/spi_eng_control.sv
module spi_eng_control
  import spi_eng_pkg::*;
#(
  parameter int BAUD_W = 16,
  localparam int HALF_W = BAUD_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              runEn,
  input  logic              txEmpty,
  input  logic              selAny,
  input  logic              cfgCpol,
  input  logic [1:0]        cfgSize,
  input  logic [BAUD_W-1:0] cfgBaud,
  output engStrobe_t        strobe,
  output logic              busy,
  output logic              sclk
);
  engState_t state;
  logic [HALF_W-1:0] halfLen, halfCnt;
  logic [4:0] edgeCnt;
  logic phase, phaseEnd, edgeNow, startFrame, lastEdge;

  // half period = divider/2 with bit 0 dropped, never below 1
  assign halfLen    = (cfgBaud[BAUD_W-1:1] == '0) ? HALF_W'(1) : cfgBaud[BAUD_W-1:1];
  assign phaseEnd   = (halfCnt == halfLen - HALF_W'(1));
  assign startFrame = (state == ST_IDLE) && runEn && !txEmpty && selAny;
  assign edgeNow    = (state == ST_RUN) && runEn && phaseEnd;
  assign lastEdge   = (edgeCnt == lastEdgeIdx(cfgSize));

  always_comb begin
    strobe.loadFrame = startFrame;
    strobe.leadEdge  = edgeNow && !edgeCnt[0];
    strobe.trailEdge = edgeNow && edgeCnt[0];
    strobe.pushRx    = (state == ST_DONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      halfCnt <= '0;
      edgeCnt <= '0;
      phase   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (startFrame) begin
          state   <= ST_RUN;
          halfCnt <= '0;
          edgeCnt <= '0;
          phase   <= 1'b0;
        end
        ST_RUN: begin
          if (!runEn) begin
            state <= ST_IDLE;
            phase <= 1'b0;
          end else if (phaseEnd) begin
            halfCnt <= '0;
            phase   <= ~phase;
            edgeCnt <= edgeCnt + 5'd1;
            if (lastEdge) state <= ST_DONE;
          end else begin
            halfCnt <= halfCnt + HALF_W'(1);
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign sclk = cfgCpol ^ phase;
endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
  import spi_eng_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 32,
  parameter int BAUD_W     = 16,
  parameter int SEL_W      = 2,
  localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [3:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [SEL_W-1:0]  csN,
  output logic              busy
);
  engStrobe_t strobe;
  logic cfgCpol, runEn, txEmpty, selAny;
  logic [1:0] cfgSize;
  logic [BAUD_W-1:0] cfgBaud;
  logic [LVL_W-1:0] txLevel, rxLevel;

  spi_eng_datapath #(
    .DATA_W(DATA_W), .DEPTH(FIFO_DEPTH), .BAUD_W(BAUD_W), .SEL_W(SEL_W)
  ) u_dp (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .strobe(strobe), .busy(busy),
    .miso(miso), .mosi(mosi), .csN(csN), .cfgCpol(cfgCpol),
    .cfgSize(cfgSize), .cfgBaud(cfgBaud), .runEn(runEn),
    .txEmpty(txEmpty), .selAny(selAny), .txLevel(txLevel), .rxLevel(rxLevel)
  );

  spi_eng_control #(.BAUD_W(BAUD_W)) u_ctl (
    .clk(clk), .rst(rst), .runEn(runEn), .txEmpty(txEmpty), .selAny(selAny),
    .cfgCpol(cfgCpol), .cfgSize(cfgSize), .cfgBaud(cfgBaud),
    .strobe(strobe), .busy(busy), .sclk(sclk)
  );
endmodule

// File: rtl/spi_eng_checker.sv
module spi_eng_checker #(
  parameter int DEPTH = 32,
  parameter int SEL_W = 2,
  parameter int LVL_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             sclk,
  input logic             cpol,
  input logic             runEn,
  input logic [LVL_W-1:0] txLevel,
  input logic [LVL_W-1:0] rxLevel,
  input logic [SEL_W-1:0] csN
);
  // R3: clock rests at the polarity level between frames
  a_r3_sclk_rests: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sclk == cpol));

  // R8: transmit queue never exceeds its depth
  a_r8_tx_bound: assert property (@(posedge clk) disable iff (rst)
    txLevel <= LVL_W'(DEPTH));

  // R8: a receive word only appears as a frame closes
  a_r8_rx_push_at_end: assert property (@(posedge clk) disable iff (rst)
    (rxLevel > $past(rxLevel)) |-> $fell(busy));

  // R7: a frame only starts when running with a slave selected
  a_r7_start_needs_run: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(runEn));
  a_r7_start_needs_select: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(csN) != {SEL_W{1'b1}}));

  // R10: stopping ends a frame on the next cycle
  a_r10_stop_aborts: assert property (@(posedge clk) disable iff (rst)
    (busy && !runEn) |=> !busy);
endmodule

bind spi_master_engine spi_eng_checker #(
  .DEPTH(FIFO_DEPTH), .SEL_W(SEL_W), .LVL_W(LVL_W)
) u_check (
  .clk(clk), .rst(rst), .busy(busy), .sclk(sclk), .cpol(cfgCpol),
  .runEn(runEn), .txLevel(txLevel), .rxLevel(rxLevel), .csN(csN)
);

// File: tb/sim_spi_master_engine.sv
module sim_spi_master_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic sclk, mosi, miso, busy;
  logic [1:0] csN;

  int checks = 0, errors = 0;
  bit finished = 0;

  // slave model state
  bit armed = 0, loopMode = 0, cpolB = 0, cphaB = 0;
  int nB = 8, sIdx = 0;
  logic [15:0] sTx = '0, sRx = '0;
  logic sMiso = 1'b0, prevSclk = 1'b0;

  assign miso = loopMode ? mosi : sMiso;

  always #2.5 clk = ~clk;

  spi_master_engine u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .sclk(sclk), .mosi(mosi),
    .miso(miso), .csN(csN), .busy(busy)
  );

  // slave: reacts half a cycle after each SCLK change
  always @(negedge clk) begin
    if (armed && sclk !== prevSclk) begin
      if ((sclk != cpolB) != cphaB) begin
        sRx = {sRx[14:0], mosi};
      end else if (!cphaB) begin
        sIdx++;
        if (sIdx < nB) sMiso = sTx[nB-1-sIdx];
      end else begin
        if (sIdx < nB) sMiso = sTx[nB-1-sIdx];
        sIdx++;
      end
    end
    prevSclk = sclk;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, input bit pop, output logic [15:0] d);
    @(negedge clk);
    addr = a; rdEn = pop;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic measureBusy(output int len);
    @(negedge clk);
    len = 0;
    while (busy && len < 5000) begin
      len++;
      @(negedge clk);
    end
  endtask

  function automatic int bitsOf(input int code);
    return (code == 0) ? 4 : (code == 2) ? 16 : 8;
  endfunction

  task automatic runFrame(input int mode, input int sizeCode, input int baud,
                          input logic [15:0] txw, input logic [15:0] sw);
    int n, half, len;
    logic [15:0] mask, d;
    n = bitsOf(sizeCode);
    half = (baud & ~1) / 2;
    if (half < 1) half = 1;
    mask = (n == 16) ? 16'hFFFF : 16'((1 << n) - 1);
    loopMode = 0;
    regWrite(4'd2, 16'd0);
    regWrite(4'd0, 16'((mode[1] << 7) | (mode[0] << 6) | sizeCode));
    regWrite(4'd1, 16'(baud));
    regWrite(4'd3, 16'd1);
    cpolB = mode[1]; cphaB = mode[0]; nB = n;
    sTx = sw; sRx = '0; sIdx = 0;
    sMiso = cphaB ? 1'b0 : sw[n-1];
    armed = 1;
    check(sclk == cpolB, "R3", "idle sclk level", sclk, cpolB);
    check(csN == 2'b10, "R6", "chip selects for slave 0", csN, 2'b10);
    regWrite(4'd2, 16'd1);
    regWrite(4'd7, txw);
    measureBusy(len);
    check(len == 2*n*half + 1, "R5", $sformatf("busy length m%0d s%0d b%0d", mode, sizeCode, baud),
          len, 2*n*half + 1);
    regRead(4'd8, 1'b1, d);
    check(d == (sw & mask), "R4", $sformatf("rx word m%0d s%0d", mode, sizeCode), d, sw & mask);
    check((sRx & mask) == (txw & mask), "R3", $sformatf("mosi bits m%0d s%0d", mode, sizeCode),
          sRx & mask, txw & mask);
    armed = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int len, guard;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    regRead(4'd6, 0, d); check(d == 16'h000C, "R1", "reset status", d, 16'h000C);
    regRead(4'd4, 0, d); check(d == 0, "R1", "reset tx level", d, 0);
    regRead(4'd5, 0, d); check(d == 0, "R1", "reset rx level", d, 0);
    regRead(4'd0, 0, d); check(d == 16'h0001, "R1", "reset control", d, 16'h0001);
    regRead(4'd1, 0, d); check(d == 16'h0002, "R1", "reset divider", d, 16'h0002);
    check(csN == 2'b11 && !busy && !sclk, "R1", "reset pins", {csN, busy, sclk}, 4'b1100);

    // R2 register readback
    regWrite(4'd0, 16'h00C2); regRead(4'd0, 0, d);
    check(d == 16'h00C2, "R2", "control readback", d, 16'h00C2);
    regWrite(4'd0, 16'hFFFF); regRead(4'd0, 0, d);
    check(d == 16'h00C3, "R2", "control unused bits", d, 16'h00C3);
    regWrite(4'd1, 16'h1234); regRead(4'd1, 0, d);
    check(d == 16'h1234, "R2", "divider readback", d, 16'h1234);

    // R3 R4 R5 sweep over modes, sizes, dividers
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 4; s++)
        for (int b = 0; b < 4; b++) begin
          int bv;
          logic [15:0] tw;
          bv = (b == 0) ? 0 : (b == 1) ? 2 : (b == 2) ? 5 : 6;
          tw = 16'hA5C3 ^ 16'(m * 16'h1357) ^ 16'(s * 16'h2468) ^ 16'(b * 16'h0F0F);
          runFrame(m, s, bv, tw, {tw[6:0], tw[15:7]} ^ 16'h5A5A);
        end

    // R6 chip selects
    regWrite(4'd2, 16'd0);
    regWrite(4'd3, 16'd2); check(csN == 2'b01, "R6", "select slave 1", csN, 2'b01);
    regWrite(4'd3, 16'd3); check(csN == 2'b00, "R6", "select both", csN, 2'b00);
    regWrite(4'd3, 16'd0); check(csN == 2'b11, "R6", "deselect", csN, 2'b11);

    // R7 R8 R9 bulk queue behaviour with loopback
    loopMode = 1;
    regWrite(4'd0, 16'h0001);
    regWrite(4'd1, 16'd2);
    for (int i = 0; i < 33; i++) regWrite(4'd7, 16'((i * 37 + 5) & 8'hFF));
    regRead(4'd4, 0, d); check(d == 32, "R8", "tx level after 33 pushes", d, 32);
    regRead(4'd6, 0, d); check(d == 16'h000A, "R9", "status tx full", d, 16'h000A);
    check(!busy, "R7", "no start while stopped", busy, 0);
    regWrite(4'd2, 16'd1);
    repeat (10) @(negedge clk);
    check(!busy, "R7", "no start without select", busy, 0);
    regRead(4'd4, 0, d); check(d == 32, "R7", "tx level held without select", d, 32);
    regWrite(4'd3, 16'd1);
    guard = 0;
    do begin
      regRead(4'd4, 0, d);
      guard++;
    end while ((d != 0 || busy) && guard < 2000);
    repeat (3) @(negedge clk);
    regRead(4'd5, 0, d); check(d == 32, "R8", "rx level after 32 frames", d, 32);
    regRead(4'd6, 0, d); check(d == 16'h0014, "R9", "status rx full tx empty", d, 16'h0014);
    regWrite(4'd7, 16'h0055);
    measureBusy(len);
    check(len == 17, "R5", "overflow frame length", len, 17);
    regRead(4'd5, 0, d); check(d == 32, "R8", "frame dropped when rx full", d, 32);
    for (int i = 0; i < 32; i++) begin
      regRead(4'd8, 1'b1, d);
      check(d == 16'((i * 37 + 5) & 8'hFF), "R8", $sformatf("rx order %0d", i),
            d, (i * 37 + 5) & 8'hFF);
    end
    regRead(4'd8, 1'b1, d);
    regRead(4'd5, 0, d); check(d == 0, "R8", "pop empty keeps level", d, 0);
    regRead(4'd6, 0, d); check(d == 16'h000C, "R9", "status both empty", d, 16'h000C);

    // R11 configuration locked while running
    regWrite(4'd0, 16'h0002);
    regRead(4'd0, 0, d); check(d == 16'h0001, "R11", "control write ignored", d, 16'h0001);
    regWrite(4'd1, 16'h0010);
    regRead(4'd1, 0, d); check(d == 16'h0002, "R11", "divider write ignored", d, 16'h0002);
    regWrite(4'd7, 16'h003C);
    measureBusy(len);
    check(len == 17, "R11", "frame uses old config", len, 17);
    regRead(4'd8, 1'b1, d); check(d == 16'h003C, "R11", "loopback word", d, 16'h003C);

    // R10 abort mid-frame
    regWrite(4'd2, 16'd0);
    regWrite(4'd1, 16'd8);
    regWrite(4'd0, 16'h0082);
    regWrite(4'd2, 16'd1);
    check(sclk == 1'b1, "R3", "idle high polarity", sclk, 1);
    regWrite(4'd7, 16'hBEEF);
    repeat (5) @(negedge clk);
    check(busy == 1'b1, "R10", "frame running", busy, 1);
    regWrite(4'd2, 16'd0);
    @(negedge clk);
    check(busy == 1'b0, "R10", "busy after stop", busy, 0);
    check(sclk == 1'b1, "R10", "sclk back to polarity", sclk, 1);
    regRead(4'd5, 0, d); check(d == 0, "R10", "no rx word from aborted frame", d, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule